// File: doc/BRIEF.md
# Buffered FFT Sequencer

This block is the control and addressing engine of an FFT accelerator that keeps all of its working data in a private 4 KiB local buffer. Software running on the processor cores programs a point count and a shared-memory base address, then pulses a start command. The engine then works through three phases that never overlap. First it copies every sample from shared memory into the local buffer. Then it computes the transform in place by repeated reads and writes of that buffer. Finally it copies the results back to shared memory.

The transform is radix-2 decimation in time. During the copy-in phase each sample lands at its bit-reversed buffer address, so the compute phase can walk the stages in natural order. The butterfly arithmetic is an external unit reached through a valid/acknowledge handshake. The sequencer supplies the two operands and a twiddle index, and it writes the two results back to the buffer. Shared memory is reached through a request/grant port. The local buffer has one write port and one read port, and read data returns one cycle after the read strobe.

Top module: `fft_buf_seq`

## Requirements
- R1: After reset, busy, done, irq and cfg_err are 0, and mem_req, bf_valid and buf_we are all 0.
- R2: A start pulse taken while idle is accepted only if cfg_npts is a power of two from 16 to 1024. Any other value sets cfg_err in the following cycle and leaves busy at 0. An accepted start clears cfg_err and done, and busy is 1 from the following cycle.
- R3: Copy-in issues N read requests (mem_we = 0) at word addresses base+0 through base+N-1 in ascending order. Each request keeps its address stable until mem_gnt, and mem_rdata is taken in the grant cycle.
- R4: The sample read from base+i is written to the buffer in its grant cycle at address rev(i), where rev reverses the low log2(N) bits of i.
- R5: No butterfly is issued before all N copy-in reads are granted, and none is issued once copy-out has begun. bf_valid and mem_req are never 1 together, and copy-out starts only after every compute-phase buffer write.
- R6: Compute runs S = log2(N) stages of N/2 butterflies each. In stage s the butterflies follow group order and then offset j inside the group, with pair addresses a = group*2^(s+1) + j and b = a + 2^s and twiddle index j << (S-1-s). bf_valid holds with stable operands and twiddle until bf_ack. Result y0 is then written to a, and on the next cycle y1 is written to b.
- R7: Butterfly operands are the buffer words at a and b, read through the one-cycle-latency read port after all writes of earlier butterflies.
- R8: Copy-out reads buffer word i and writes it to shared memory at base+i with mem_we = 1, in ascending order. Each request is held until granted.
- R9: In the cycle after the last copy-out grant, irq is 1 for exactly one cycle, done is 1 and busy is 0. done stays 1 until the next accepted start.
- R10: Start pulses and changes to cfg_npts or cfg_base while busy are ignored, so the run in progress keeps its original point count and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start command pulse |
| cfg_npts | input | 11 | Point count N |
| cfg_base | input | 32 | Shared-memory base word address |
| busy | output | 1 | Engine running |
| done | output | 1 | Last run finished |
| irq | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start rejected for a bad point count |
| mem_req | output | 1 | Shared-memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Shared-memory word address |
| mem_wdata | output | 32 | Shared-memory write data |
| mem_gnt | input | 1 | Shared-memory grant |
| mem_rdata | input | 32 | Shared-memory read data, valid with grant |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | 10 | Buffer write address |
| buf_wdata | output | 32 | Buffer write data |
| buf_re | output | 1 | Buffer read strobe |
| buf_raddr | output | 10 | Buffer read address |
| buf_rdata | input | 32 | Buffer read data, one cycle after buf_re |
| bf_valid | output | 1 | Butterfly operands valid |
| bf_x0 | output | 32 | Butterfly operand at address a |
| bf_x1 | output | 32 | Butterfly operand at address b |
| bf_tw | output | 9 | Twiddle index |
| bf_ack | input | 1 | Butterfly results valid |
| bf_y0 | input | 32 | Result for address a |
| bf_y1 | input | 32 | Result for address b |

## Verification
Runs use 16, 32, 64 and 1024 points with random words, a single impulse and a ramp. Random data shows whether any buffer word ends up in the wrong place. The impulse isolates one bit-reversal path, and the ramp exposes swapped pair addresses. The bench's butterfly model folds the twiddle index into its second result, so a wrong twiddle or a swapped y0/y1 write changes the final shared-memory image. Grants and acknowledges are given either at once or after random stalls, which separates hold-until-grant behaviour from plain timing. Rejected point counts at 8, 100 and 2048, and a start injected mid-run with a different base, test the R2 and R10 paths.

// File: rtl/fft_seq_pkg.sv
// Shared types and helpers for the buffered FFT sequencer.
// Assumes point counts fit in 16 bits.
package fft_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_IN,
        S_CRD0, S_CRD1, S_CCAP, S_CBF, S_CWR0, S_CWR1,
        S_ORD, S_OCAP, S_OWR
    } seq_state_t;

    // Index of the highest set bit (log2 of a power of two).
    function automatic logic [4:0] log2_pow(input logic [15:0] v);
        logic [4:0] r;
        r = '0;
        for (int k = 0; k < 16; k++) begin
            if (v[k]) r = 5'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/fft_seq_bitrev.sv
// Reverses the low lg bits of an index. Assumes lg <= ABW.
module fft_seq_bitrev #(
    parameter int ABW = 10,
    parameter int LW  = 4
) (
    input  logic [ABW-1:0] idx,
    input  logic [LW-1:0]  lg,
    output logic [ABW-1:0] rev
);
    localparam logic [LW-1:0] ABW_L = LW'(ABW);

    logic [ABW-1:0] full;

    // Mirror the whole field, then drop the unused low bits.
    for (genvar k = 0; k < ABW; k++) begin : g_mirror
        assign full[k] = idx[ABW-1-k];
    end

    assign rev = full >> (ABW_L - lg);
endmodule

// File: rtl/fft_seq_pair_addr.sv
// Maps butterfly number, stage and log2(N) to the pair addresses and twiddle index
// for radix-2 decimation in time. Assumes stg < lg and bidx < N/2.
module fft_seq_pair_addr #(
    parameter int ABW = 10,
    parameter int LW  = 4
) (
    input  logic [ABW-2:0] bidx,
    input  logic [LW-1:0]  stg,
    input  logic [LW-1:0]  lg,
    output logic [ABW-1:0] addr_a,
    output logic [ABW-1:0] addr_b,
    output logic [ABW-2:0] tw
);
    logic [ABW-1:0] mask;
    logic [ABW-1:0] bx;
    logic [ABW-1:0] twf;
    logic [LW-1:0]  tsh;

    // Offset inside the group uses the low stg bits; the group bits shift up one place.
    assign mask   = (ABW'(1) << stg) - ABW'(1);
    assign bx     = {1'b0, bidx};
    assign addr_a = ((bx & ~mask) << 1) | (bx & mask);
    assign addr_b = addr_a | (ABW'(1) << stg);
    assign tsh    = lg - stg - LW'(1);
    assign twf    = (bx & mask) << tsh;
    assign tw     = twf[ABW-2:0];
endmodule

// File: rtl/fft_buf_seq.sv
// Three-phase buffered FFT sequencer: copy-in with bit-reversed placement,
// in-place radix-2 compute over the local buffer, then copy-out.
// Assumes read data of the buffer arrives one cycle after buf_re and that
// shared-memory read data is valid in the grant cycle.
module fft_buf_seq
    import fft_seq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int BUF_BYTES = 4096,
    parameter int MIN_PTS   = 16,
    localparam int DEPTH    = BUF_BYTES * 8 / DW,
    localparam int ABW      = $clog2(DEPTH),
    localparam int NW       = ABW + 1,
    localparam int LW       = $clog2(ABW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_start,
    input  logic [NW-1:0]  cfg_npts,
    input  logic [AW-1:0]  cfg_base,
    output logic           busy,
    output logic           done,
    output logic           irq,
    output logic           cfg_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic           buf_we,
    output logic [ABW-1:0] buf_waddr,
    output logic [DW-1:0]  buf_wdata,
    output logic           buf_re,
    output logic [ABW-1:0] buf_raddr,
    input  logic [DW-1:0]  buf_rdata,
    output logic           bf_valid,
    output logic [DW-1:0]  bf_x0,
    output logic [DW-1:0]  bf_x1,
    output logic [ABW-2:0] bf_tw,
    input  logic           bf_ack,
    input  logic [DW-1:0]  bf_y0,
    input  logic [DW-1:0]  bf_y1
);
    seq_state_t     st;
    logic [ABW-1:0] cnt;
    logic [LW-1:0]  stg;
    logic [LW-1:0]  lg;
    logic [AW-1:0]  base_q;
    logic [DW-1:0]  x0, x1, odata;

    logic [ABW-1:0] rev_idx, addr_a, addr_b, pts_m1, half_m1;
    logic [ABW-2:0] tw;
    logic           npts_ok;

    fft_seq_bitrev #(.ABW(ABW), .LW(LW)) u_rev (
        .idx(cnt), .lg(lg), .rev(rev_idx)
    );

    fft_seq_pair_addr #(.ABW(ABW), .LW(LW)) u_pair (
        .bidx(cnt[ABW-2:0]), .stg(stg), .lg(lg),
        .addr_a(addr_a), .addr_b(addr_b), .tw(tw)
    );

    // Legal point count: single bit set, within buffer range.
    assign npts_ok = ((cfg_npts & (cfg_npts - NW'(1))) == '0)
                   && (cfg_npts >= NW'(MIN_PTS)) && (cfg_npts <= NW'(DEPTH));
    assign pts_m1  = ABW'((NW'(1) << lg) - NW'(1));
    assign half_m1 = pts_m1 >> 1;

    // Phase sequencer with index, stage and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            stg     <= '0;
            lg      <= LW'(MIN_PTS > 1 ? $clog2(MIN_PTS) : 1);
            base_q  <= '0;
            x0      <= '0;
            x1      <= '0;
            odata   <= '0;
            done    <= 1'b0;
            irq     <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                S_IDLE: if (cfg_start) begin
                    if (npts_ok) begin
                        lg      <= LW'(log2_pow(16'(cfg_npts)));
                        base_q  <= cfg_base;
                        cnt     <= '0;
                        done    <= 1'b0;
                        cfg_err <= 1'b0;
                        st      <= S_IN;
                    end else begin
                        cfg_err <= 1'b1;
                    end
                end
                S_IN: if (mem_gnt) begin
                    if (cnt == pts_m1) begin
                        cnt <= '0;
                        stg <= '0;
                        st  <= S_CRD0;
                    end else begin
                        cnt <= cnt + ABW'(1);
                    end
                end
                S_CRD0: st <= S_CRD1;
                S_CRD1: begin
                    x0 <= buf_rdata;
                    st <= S_CCAP;
                end
                S_CCAP: begin
                    x1 <= buf_rdata;
                    st <= S_CBF;
                end
                S_CBF: if (bf_ack) begin
                    x0 <= bf_y0;
                    x1 <= bf_y1;
                    st <= S_CWR0;
                end
                S_CWR0: st <= S_CWR1;
                S_CWR1: begin
                    st <= S_CRD0;
                    if (cnt == half_m1) begin
                        cnt <= '0;
                        if (stg == lg - LW'(1)) st <= S_ORD;
                        else                    stg <= stg + LW'(1);
                    end else begin
                        cnt <= cnt + ABW'(1);
                    end
                end
                S_ORD: st <= S_OCAP;
                S_OCAP: begin
                    odata <= buf_rdata;
                    st    <= S_OWR;
                end
                S_OWR: if (mem_gnt) begin
                    if (cnt == pts_m1) begin
                        done <= 1'b1;
                        irq  <= 1'b1;
                        st   <= S_IDLE;
                    end else begin
                        cnt <= cnt + ABW'(1);
                        st  <= S_ORD;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port decoding from the current phase.
    always_comb begin
        busy      = (st != S_IDLE);
        mem_req   = (st == S_IN) || (st == S_OWR);
        mem_we    = (st == S_OWR);
        mem_addr  = base_q + AW'(cnt);
        mem_wdata = odata;
        buf_we    = ((st == S_IN) && mem_gnt) || (st == S_CWR0) || (st == S_CWR1);
        buf_waddr = (st == S_IN) ? rev_idx : (st == S_CWR0) ? addr_a : addr_b;
        buf_wdata = (st == S_IN) ? mem_rdata : (st == S_CWR0) ? x0 : x1;
        buf_re    = (st == S_CRD0) || (st == S_CRD1) || (st == S_ORD);
        buf_raddr = (st == S_CRD0) ? addr_a : (st == S_CRD1) ? addr_b : cnt;
        bf_valid  = (st == S_CBF);
        bf_x0     = x0;
        bf_x1     = x1;
        bf_tw     = tw;
    end
endmodule

// File: rtl/fft_buf_seq_chk.sv
// Protocol checker for fft_buf_seq, bound to every instance.
// Assumes the same parameter values as the bound instance.
module fft_buf_seq_chk #(
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int ABW = 10,
    parameter int NW  = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_start,
    input logic [NW-1:0]  cfg_npts,
    input logic           busy,
    input logic           done,
    input logic           irq,
    input logic           cfg_err,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_gnt,
    input logic           bf_valid,
    input logic           bf_ack,
    input logic [ABW-2:0] bf_tw,
    input logic [DW-1:0]  bf_x0
);
    logic npts_ok;
    assign npts_ok = ($countones(cfg_npts) == 1) && (cfg_npts >= NW'(16))
                   && (cfg_npts <= NW'(1 << ABW));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bf_valid && mem_req));

    p_bf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bf_valid && !bf_ack |=> bf_valid && $stable(bf_tw) && $stable(bf_x0));

    p_bad_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cfg_start && !npts_ok |=> cfg_err && !busy);

    p_irq_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done && !busy);

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_start && !(mem_req && mem_we && mem_gnt) |=> busy);
endmodule

bind fft_buf_seq fft_buf_seq_chk #(.DW(DW), .AW(AW), .ABW(ABW), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_npts(cfg_npts),
    .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .bf_valid(bf_valid), .bf_ack(bf_ack), .bf_tw(bf_tw), .bf_x0(bf_x0)
);

// File: tb/fft_buf_seq_test.sv
`timescale 1ns/1ps
module fft_buf_seq_test;
    localparam int DW = 32, AW = 32, ABW = 10, NW = 11;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_start = 1'b0;
    logic [NW-1:0] cfg_npts = '0;
    logic [AW-1:0] cfg_base = '0;
    logic busy, done, irq, cfg_err;
    logic mem_req, mem_we, mem_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic buf_we, buf_re;
    logic [ABW-1:0] buf_waddr, buf_raddr;
    logic [DW-1:0] buf_wdata, buf_rdata;
    logic bf_valid, bf_ack = 1'b0;
    logic [DW-1:0] bf_x0, bf_x1, bf_y0 = '0, bf_y1 = '0;
    logic [ABW-2:0] bf_tw;

    fft_buf_seq uut (.*);

    // Local buffer model: one write port, registered read port.
    logic [DW-1:0] bmem [1024];
    logic [DW-1:0] brd = '0;
    always @(posedge clk) begin
        if (buf_we) bmem[buf_waddr] <= buf_wdata;
        if (buf_re) brd <= bmem[buf_raddr];
    end
    assign buf_rdata = brd;

    logic [DW-1:0] smem [4096];
    logic [DW-1:0] inp [1024];
    logic [DW-1:0] refb [1024];

    int total = 0, bad = 0;
    int n = 16, lgn = 4, base = 0;
    int rd_cnt = 0, wr_cnt = 0, bf_cnt = 0, bw_cnt = 0;
    int gnt_mode = 0, ack_mode = 0;
    bit exp_busy = 0, exp_done = 0, exp_irq = 0, exp_err = 0;
    bit pend_start = 0, pend_err = 0, pend_fin = 0;
    int qa[$], qb[$], qt[$];
    logic [DW-1:0] ly0 = '0, ly1 = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int brev(input int i, input int l);
        int r = 0;
        for (int k = 0; k < l; k++) if ((i >> k) & 1) r |= 1 << (l - 1 - k);
        return r;
    endfunction

    function automatic bit pts_ok(input int v);
        return (v >= 16) && (v <= 1024) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int ilog2(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    function automatic logic [DW-1:0] fy1(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                         input int t);
        return a - b + DW'(t * 7 + 1);
    endfunction

    // Reference model and responders, compared on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_start) begin exp_busy = 1; exp_done = 0; exp_err = 0; pend_start = 0; end
            if (pend_err) begin exp_err = 1; pend_err = 0; end
            if (pend_fin) begin exp_busy = 0; exp_done = 1; exp_irq = 1; pend_fin = 0; end
            check(busy === exp_busy, "R10", "busy", busy, exp_busy);
            check(done === exp_done, "R9", "done", done, exp_done);
            check(irq === exp_irq, "R9", "irq", irq, exp_irq);
            check(cfg_err === exp_err, "R2", "cfg_err", cfg_err, exp_err);
            exp_irq = 0;
            mem_gnt = mem_req && (gnt_mode == 0 || $urandom_range(0, 2) == 0);
            bf_ack  = bf_valid && (ack_mode == 0 || $urandom_range(0, 2) == 0);
            if (mem_gnt && !mem_we) mem_rdata = smem[mem_addr[11:0]];
            if (bf_ack) begin
                ly0 = bf_x0 + bf_x1;
                ly1 = fy1(bf_x0, bf_x1, int'(bf_tw));
                bf_y0 = ly0;
                bf_y1 = ly1;
            end
            #1;
            if (mem_gnt && !mem_we) begin
                check(rd_cnt < n && mem_addr == AW'(base + rd_cnt), "R3", "read addr",
                      mem_addr, base + rd_cnt);
                check(buf_we && buf_waddr == ABW'(brev(rd_cnt, lgn)) && buf_wdata == mem_rdata,
                      "R4", "bitrev write", buf_waddr, brev(rd_cnt, lgn));
                rd_cnt++;
            end else if (mem_gnt && mem_we) begin
                check(bw_cnt == n * lgn && mem_addr == AW'(base + wr_cnt), "R8", "write addr",
                      mem_addr, base + wr_cnt);
                smem[mem_addr[11:0]] = mem_wdata;
                wr_cnt++;
                if (wr_cnt == n) pend_fin = 1;
            end else if (buf_we) begin
                int k;
                k = bw_cnt / 2;
                check(rd_cnt == n && wr_cnt == 0 && k < qa.size(), "R5", "compute phase",
                      rd_cnt, n);
                if (k < qa.size()) begin
                    if (bw_cnt % 2 == 0)
                        check(buf_waddr == ABW'(qa[k]) && buf_wdata == ly0, "R6", "y0 write",
                              buf_waddr, qa[k]);
                    else
                        check(buf_waddr == ABW'(qb[k]) && buf_wdata == ly1, "R6", "y1 write",
                              buf_waddr, qb[k]);
                end
                bw_cnt++;
            end
            if (bf_ack) begin
                check(rd_cnt == n && wr_cnt == 0, "R5", "issue phase", rd_cnt, n);
                check(bf_cnt < qt.size() && int'(bf_tw) == qt[bf_cnt], "R6", "twiddle",
                      bf_tw, (bf_cnt < qt.size()) ? qt[bf_cnt] : -1);
                bf_cnt++;
            end
            if (cfg_start && !exp_busy) begin
                if (pts_ok(int'(cfg_npts))) begin
                    pend_start = 1;
                    n = int'(cfg_npts); lgn = ilog2(n); base = int'(cfg_base);
                    rd_cnt = 0; wr_cnt = 0; bf_cnt = 0; bw_cnt = 0;
                    qa.delete(); qb.delete(); qt.delete();
                    for (int s = 0; s < lgn; s++)
                        for (int g = 0; g < n; g += 2 << s)
                            for (int j = 0; j < (1 << s); j++) begin
                                qa.push_back(g + j);
                                qb.push_back(g + j + (1 << s));
                                qt.push_back(j << (lgn - 1 - s));
                            end
                end else begin
                    pend_err = 1;
                end
            end
        end
    end

    task automatic pulse_start(input int np, input int b);
        @(posedge clk); #1;
        cfg_npts = NW'(np); cfg_base = AW'(b); cfg_start = 1'b1;
        @(posedge clk); #1;
        cfg_start = 1'b0;
    endtask

    task automatic run_case(input int np, input int b, input int gm, input int am,
                            input int pat, input bit poke);
        int w = 0, lg, mism = 0, first = -1;
        logic [DW-1:0] t0, t1;
        for (int i = 0; i < np; i++) begin
            inp[i] = (pat == 0) ? $urandom() : (pat == 1) ? DW'(i == 1 ? 100 : 0) : DW'(i * 3 + 5);
            smem[b + i] = inp[i];
        end
        gnt_mode = gm; ack_mode = am;
        pulse_start(np, b);
        if (poke) begin
            repeat (20) @(posedge clk);
            pulse_start(16, b + 1500);
        end
        repeat (2) @(posedge clk);
        while (!exp_done && w < 60000) begin @(posedge clk); w++; end
        check(w < 60000, "R9", "watchdog", w, 60000);
        lg = ilog2(np);
        for (int i = 0; i < np; i++) refb[brev(i, lg)] = inp[i];
        for (int s = 0; s < lg; s++)
            for (int g = 0; g < np; g += 2 << s)
                for (int j = 0; j < (1 << s); j++) begin
                    t0 = refb[g + j]; t1 = refb[g + j + (1 << s)];
                    refb[g + j] = t0 + t1;
                    refb[g + j + (1 << s)] = fy1(t0, t1, j << (lg - 1 - s));
                end
        for (int i = 0; i < np; i++)
            if (smem[b + i] !== refb[i]) begin mism++; if (first < 0) first = i; end
        check(mism == 0, "R7", $sformatf("result n=%0d word %0d", np, first),
              (first < 0) ? 0 : smem[b + first], (first < 0) ? 0 : refb[first]);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) smem[i] = '0;
        for (int i = 0; i < 1024; i++) bmem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!busy && !done && !irq && !cfg_err, "R1", "status", {busy, done, irq, cfg_err}, 0);
        check(!mem_req && !bf_valid && !buf_we, "R1", "ports", {mem_req, bf_valid, buf_we}, 0);
        rst_n = 1'b1;
        // R2: rejected counts
        pulse_start(100, 0);
        pulse_start(8, 0);
        pulse_start(2048, 0);
        repeat (2) @(posedge clk); #1;
        check(!busy && cfg_err, "R2", "rejected", {busy, cfg_err}, 1);
        run_case(16, 64, 0, 0, 2, 0);
        run_case(16, 512, 1, 1, 1, 0);
        run_case(32, 700, 1, 0, 0, 0);
        run_case(64, 1000, 1, 1, 0, 1);   // R10: start mid-run ignored
        run_case(1024, 2048, 0, 0, 0, 0);
        repeat (4) @(posedge clk); #1;
        check(done && !busy, "R9", "done held", {done, busy}, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule